// File: doc/BRIEF.md
# Interrupt Presenter Register Front End

This block is the memory-mapped register face of a bank of per-processor interrupt presentation units. Each access carries a 20-bit window address, a size of 1 to 4 bytes, a direction and write data. The upper address bits pick the server, meaning the presentation unit of one processor, and each server owns one 4 KB page. The remaining bits pick a register inside that page. The block checks the size and byte alignment of every access. It then turns the access into one of these operations: a poll, an accept, a priority change, an end-of-interrupt, an inter-processor request update or a link word access.

Each unit keeps a current processor priority, one pending external source with its priority, an inter-processor request priority and three 32-bit link words. A lower priority number is more favoured, and 0xFF is the least favoured. A unit raises its interrupt line while it has something to present that beats its current priority. Source controllers outside this block hand pending interrupts in through a small delivery port.

Single-byte accesses carry their byte in data bits [7:0]. A read answers with bits [31:8] cleared. Every access, legal or not, gets a response one cycle later.

Top module: `ipres_mmio_top`

## Requirements
- R1: After reset every unit has current priority 0x00, no pending source (pending priority 0xFF), request priority 0xFF and all link words 0. rspValid, errPulse and irq are all low.
- R2: Address bits [19:12] give the server number and bits [11:2] give the register offset. A server number at or above NUM_SERVERS is a bad access.
- R3: Every request gets rspValid for exactly one cycle, in the cycle after the request. A write always answers rspData 0. With no request, rspValid stays low.
- R4: A 4-byte read at offset 0 returns the request word {current priority[31:24], presented source[23:0]} and changes no state. The presented source is 0 when nothing beats the current priority.
- R5: A byte-0 access is a 1-byte access with address bits [1:0] equal to 00. A byte-0 read at offset 0 or offset 4 returns the current priority in bits [7:0] and changes no state. Any other 1-byte alignment is a bad access.
- R6: A 4-byte read at offset 4 is an accept. It returns the same word as R4. If something is presented, the current priority becomes the presented priority, and a presented external source is cleared to 0. With nothing presented, no state changes.
- R7: A byte-0 write at offset 4 sets the current priority to data[7:0].
- R8: A 4-byte write at offset 4 is an end-of-interrupt and sets the current priority to data[31:24].
- R9: Offset 12 takes byte-0 accesses only. A read returns the request priority and a write sets it from data[7:0]. Any other width at this offset is a bad access and leaves the value unchanged.
- R10: The request presents source 2 when its priority is numerically lower than the current priority and, if an external source is pending, also lower than that source's priority. On a tie the external source wins.
- R11: Offsets 16, 20 and 24 are three independent 32-bit link words, private to each server. Only 4-byte accesses may read or write them.
- R12: A bad access is an unknown offset, an illegal width or alignment (sizes 2 and 3 are never legal, offset 0 cannot be written), or a missing server. It pulses errPulse with its response. A bad read returns 0xFFFFFFFF and a bad write changes nothing.
- R13: irq[n] is high exactly while unit n presents a source, that is, while an external source or the request is more favoured than its current priority.
- R14: A delivery (srcValid, srcServer, srcNum non-zero, srcPrio) is stored in the addressed unit when that unit holds no pending source, or when srcPrio is numerically lower than the stored pending priority. Any other delivery, including one to a missing server, is dropped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Access request this cycle |
| reqWrite | input | 1 | 1 = write, 0 = read |
| reqAddr | input | ADDR_W (20) | Window address: server in [19:12], offset in [11:2], byte in [1:0] |
| reqSize | input | 3 | Access size in bytes, 1 to 4 |
| reqWdata | input | DATA_W (32) | Write data; a byte access uses [7:0] |
| rspValid | output | 1 | Response strobe, one cycle after each request |
| rspData | output | DATA_W (32) | Read data; 0 for writes |
| errPulse | output | 1 | High with the response of a bad access |
| srcValid | input | 1 | Pending-interrupt delivery strobe |
| srcServer | input | ADDR_W-PAGE_BITS (8) | Target server of the delivery |
| srcNum | input | SRC_W (24) | Delivered source number, non-zero |
| srcPrio | input | PRIO_W (8) | Delivered source priority |
| irq | output | NUM_SERVERS (4) | Per-unit interrupt line |

## Verification
The register decode is tried with one access sequence that sweeps every offset with each size and alignment. The same offset is used for both a byte access and a word access, which shows whether the decode uses the width to tell poll from accept and priority-set from end-of-interrupt. Accesses to a missing server, to unknown offsets and with odd sizes show whether error responses stay separate from legal ones. A read-back after each rejected write shows that the rejected write left the state alone. Presentation is tried with three patterns: the request alone, the request against a pending external source at equal and at lower priority numbers, and external deliveries that either beat or lose to the pending source. Together these show the priority order among request, external source and current priority, and they show the accept cycle that follows.

// File: rtl/ipres_pkg.sv
package ipres_pkg;

  // Control-to-datapath strobes for one decoded access
  typedef struct packed {
    logic       poll;     // return request word (no side effect)
    logic       accept;   // return request word and take the interrupt
    logic       setPrio;  // byte write of current priority
    logic       eoi;      // word write ending an interrupt
    logic       ipiWr;    // write request priority
    logic       ipiRd;    // read request priority
    logic       linkWr;   // write one link word
    logic       linkRd;   // read one link word
    logic [1:0] linkSel;  // which link word
    logic       topByte;  // narrow read: only priority byte
    logic       bad;      // illegal access
  } ctrlStrobeT;

  // Register offsets in units of 4 bytes (address bits [11:2])
  localparam int unsigned OFS_POLL  = 0;
  localparam int unsigned OFS_XIRR  = 1;
  localparam int unsigned OFS_IPI   = 3;
  localparam int unsigned OFS_LINK0 = 4;
  localparam int unsigned OFS_LINK1 = 5;
  localparam int unsigned OFS_LINK2 = 6;

endpackage

// File: rtl/ipres_decode.sv
module ipres_decode
  import ipres_pkg::*;
#(
  parameter int unsigned NUM_SERVERS = 4,
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned PAGE_BITS   = 12
) (
  input  logic                          reqValid,
  input  logic                          reqWrite,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic [2:0]                    reqSize,
  output ctrlStrobeT                    stb,
  output logic [ADDR_W-PAGE_BITS-1:0]   serverIdx
);

  localparam int unsigned SRV_W = ADDR_W - PAGE_BITS;
  localparam int unsigned OFS_W = PAGE_BITS - 2;
  localparam logic [SRV_W:0] SRV_LIMIT = (SRV_W+1)'(NUM_SERVERS);

  logic [OFS_W-1:0] ofs;
  logic             isByte0;
  logic             isWord;
  logic             srvExists;
  ctrlStrobeT       raw;

  assign serverIdx = reqAddr[ADDR_W-1:PAGE_BITS];
  assign ofs       = reqAddr[PAGE_BITS-1:2];
  assign isByte0   = (reqSize == 3'd1) && (reqAddr[1:0] == 2'b00);
  assign isWord    = (reqSize == 3'd4) && (reqAddr[1:0] == 2'b00);
  assign srvExists = ({1'b0, serverIdx} < SRV_LIMIT);

  always_comb begin
    raw = '0;
    if (ofs == OFS_W'(OFS_POLL)) begin
      if (!reqWrite && isWord) begin
        raw.poll = 1'b1;
      end else if (!reqWrite && isByte0) begin
        raw.poll    = 1'b1;
        raw.topByte = 1'b1;
      end else begin
        raw.bad = 1'b1;
      end
    end else if (ofs == OFS_W'(OFS_XIRR)) begin
      if (reqWrite) begin
        if (isByte0)     raw.setPrio = 1'b1;
        else if (isWord) raw.eoi     = 1'b1;
        else             raw.bad     = 1'b1;
      end else begin
        if (isWord) begin
          raw.accept = 1'b1;
        end else if (isByte0) begin
          raw.poll    = 1'b1;
          raw.topByte = 1'b1;
        end else begin
          raw.bad = 1'b1;
        end
      end
    end else if (ofs == OFS_W'(OFS_IPI)) begin
      if (isByte0) begin
        raw.ipiWr = reqWrite;
        raw.ipiRd = !reqWrite;
      end else begin
        raw.bad = 1'b1;
      end
    end else if (ofs == OFS_W'(OFS_LINK0) || ofs == OFS_W'(OFS_LINK1) ||
                 ofs == OFS_W'(OFS_LINK2)) begin
      if (isWord) begin
        raw.linkWr  = reqWrite;
        raw.linkRd  = !reqWrite;
        raw.linkSel = ofs[1:0];
      end else begin
        raw.bad = 1'b1;
      end
    end else begin
      raw.bad = 1'b1;
    end
  end

  always_comb begin
    stb = '0;
    if (reqValid) begin
      if (srvExists) stb = raw;
      else           stb.bad = 1'b1;
    end
  end

endmodule

// File: rtl/ipres_unit.sv
module ipres_unit #(
  parameter int unsigned PRIO_W    = 8,
  parameter int unsigned SRC_W     = 24,
  parameter int unsigned NUM_LINKS = 3,
  parameter int unsigned IPI_SRC   = 2
) (
  input  logic                                  clk,
  input  logic                                  rstN,
  input  logic                                  doAccept,
  input  logic                                  doSetPrio,
  input  logic                                  doEoi,
  input  logic                                  doIpiWr,
  input  logic                                  doLinkWr,
  input  logic [1:0]                            linkSel,
  input  logic [PRIO_W+SRC_W-1:0]               wdata,
  input  logic                                  srcLoad,
  input  logic [SRC_W-1:0]                      srcNum,
  input  logic [PRIO_W-1:0]                     srcPrio,
  output logic [PRIO_W+SRC_W-1:0]               pollWord,
  output logic [PRIO_W-1:0]                     ipiPrio,
  output logic [NUM_LINKS-1:0][PRIO_W+SRC_W-1:0] linkWords,
  output logic                                  irq
);

  localparam int unsigned DATA_W = PRIO_W + SRC_W;
  localparam logic [PRIO_W-1:0] LEAST = '1;

  logic [PRIO_W-1:0] curPrio;
  logic [PRIO_W-1:0] pendPrio;
  logic [SRC_W-1:0]  pendSrc;
  logic [PRIO_W-1:0] ipiQ;
  logic [DATA_W-1:0] linkQ [NUM_LINKS];

  logic              extValid;
  logic              ipiWins;
  logic              extWins;
  logic [SRC_W-1:0]  presSrc;
  logic [PRIO_W-1:0] presPrio;
  logic [SRC_W-1:0]  nxtSrc;
  logic [PRIO_W-1:0] nxtPrio;

  // Presentation: request beats external only when strictly more favoured
  assign extValid = (pendSrc != '0);
  assign ipiWins  = (ipiQ < curPrio) && (!extValid || (ipiQ < pendPrio));
  assign extWins  = !ipiWins && extValid && (pendPrio < curPrio);

  always_comb begin
    presSrc  = '0;
    presPrio = LEAST;
    if (ipiWins) begin
      presSrc  = SRC_W'(IPI_SRC);
      presPrio = ipiQ;
    end else if (extWins) begin
      presSrc  = pendSrc;
      presPrio = pendPrio;
    end
  end

  assign pollWord = {curPrio, presSrc};
  assign ipiPrio  = ipiQ;
  assign irq      = ipiWins || extWins;

  // Pending slot update: accept clears a taken external, then delivery
  always_comb begin
    nxtSrc  = pendSrc;
    nxtPrio = pendPrio;
    if (doAccept && extWins) begin
      nxtSrc  = '0;
      nxtPrio = LEAST;
    end
    if (srcLoad && (srcNum != '0) && ((nxtSrc == '0) || (srcPrio < nxtPrio))) begin
      nxtSrc  = srcNum;
      nxtPrio = srcPrio;
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curPrio  <= '0;
      pendSrc  <= '0;
      pendPrio <= LEAST;
      ipiQ     <= LEAST;
    end else begin
      pendSrc  <= nxtSrc;
      pendPrio <= nxtPrio;
      if (doAccept && (ipiWins || extWins)) curPrio <= presPrio;
      else if (doSetPrio)                   curPrio <= wdata[PRIO_W-1:0];
      else if (doEoi)                       curPrio <= wdata[DATA_W-1 -: PRIO_W];
      if (doIpiWr) ipiQ <= wdata[PRIO_W-1:0];
    end
  end

  for (genvar g = 0; g < NUM_LINKS; g++) begin : gLink
    always_ff @(posedge clk) begin
      if (!rstN)                               linkQ[g] <= '0;
      else if (doLinkWr && linkSel == 2'(g))   linkQ[g] <= wdata;
    end
    assign linkWords[g] = linkQ[g];
  end

endmodule

// File: rtl/ipres_bank.sv
module ipres_bank
  import ipres_pkg::*;
#(
  parameter int unsigned NUM_SERVERS = 4,
  parameter int unsigned SRV_W       = 8,
  parameter int unsigned PRIO_W      = 8,
  parameter int unsigned SRC_W       = 24
) (
  input  logic                    clk,
  input  logic                    rstN,
  input  logic                    reqValid,
  input  logic                    reqWrite,
  input  ctrlStrobeT              stb,
  input  logic [SRV_W-1:0]        serverIdx,
  input  logic [PRIO_W+SRC_W-1:0] wdata,
  input  logic                    srcValid,
  input  logic [SRV_W-1:0]        srcServer,
  input  logic [SRC_W-1:0]        srcNum,
  input  logic [PRIO_W-1:0]       srcPrio,
  output logic                    rspValid,
  output logic [PRIO_W+SRC_W-1:0] rspData,
  output logic                    errPulse,
  output logic [NUM_SERVERS-1:0]  irq
);

  localparam int unsigned DATA_W    = PRIO_W + SRC_W;
  localparam int unsigned NUM_LINKS = 3;

  logic [DATA_W-1:0]                 pollArr [NUM_SERVERS];
  logic [PRIO_W-1:0]                 ipiArr  [NUM_SERVERS];
  logic [NUM_LINKS-1:0][DATA_W-1:0]  linkArr [NUM_SERVERS];

  logic [DATA_W-1:0]                 selPoll;
  logic [PRIO_W-1:0]                 selIpi;
  logic [NUM_LINKS-1:0][DATA_W-1:0]  selLinks;
  logic [DATA_W-1:0]                 readVal;

  for (genvar i = 0; i < NUM_SERVERS; i++) begin : gUnit
    logic hit;
    assign hit = (serverIdx == SRV_W'(i));

    ipres_unit #(
      .PRIO_W    (PRIO_W),
      .SRC_W     (SRC_W),
      .NUM_LINKS (NUM_LINKS),
      .IPI_SRC   (2)
    ) u_unit (
      .clk       (clk),
      .rstN      (rstN),
      .doAccept  (hit && stb.accept),
      .doSetPrio (hit && stb.setPrio),
      .doEoi     (hit && stb.eoi),
      .doIpiWr   (hit && stb.ipiWr),
      .doLinkWr  (hit && stb.linkWr),
      .linkSel   (stb.linkSel),
      .wdata     (wdata),
      .srcLoad   (srcValid && (srcServer == SRV_W'(i))),
      .srcNum    (srcNum),
      .srcPrio   (srcPrio),
      .pollWord  (pollArr[i]),
      .ipiPrio   (ipiArr[i]),
      .linkWords (linkArr[i]),
      .irq       (irq[i])
    );
  end

  always_comb begin
    selPoll  = '0;
    selIpi   = '0;
    selLinks = '0;
    for (int i = 0; i < NUM_SERVERS; i++) begin
      if (serverIdx == SRV_W'(i)) begin
        selPoll  = pollArr[i];
        selIpi   = ipiArr[i];
        selLinks = linkArr[i];
      end
    end
  end

  always_comb begin
    readVal = '0;
    if (reqWrite) begin
      readVal = '0;
    end else if (stb.bad) begin
      readVal = '1;
    end else if (stb.poll || stb.accept) begin
      readVal = stb.topByte ? {{SRC_W{1'b0}}, selPoll[DATA_W-1 -: PRIO_W]} : selPoll;
    end else if (stb.ipiRd) begin
      readVal = {{SRC_W{1'b0}}, selIpi};
    end else if (stb.linkRd) begin
      readVal = selLinks[stb.linkSel];
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      rspValid <= 1'b0;
      rspData  <= '0;
      errPulse <= 1'b0;
    end else begin
      rspValid <= reqValid;
      rspData  <= reqValid ? readVal : '0;
      errPulse <= reqValid && stb.bad;
    end
  end

endmodule

// File: rtl/ipres_mmio_top.sv
module ipres_mmio_top
  import ipres_pkg::*;
#(
  parameter int unsigned NUM_SERVERS = 4,
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned PAGE_BITS   = 12,
  parameter int unsigned PRIO_W      = 8,
  parameter int unsigned SRC_W       = 24
) (
  input  logic                            clk,
  input  logic                            rstN,
  input  logic                            reqValid,
  input  logic                            reqWrite,
  input  logic [ADDR_W-1:0]               reqAddr,
  input  logic [2:0]                      reqSize,
  input  logic [PRIO_W+SRC_W-1:0]         reqWdata,
  output logic                            rspValid,
  output logic [PRIO_W+SRC_W-1:0]         rspData,
  output logic                            errPulse,
  input  logic                            srcValid,
  input  logic [ADDR_W-PAGE_BITS-1:0]     srcServer,
  input  logic [SRC_W-1:0]                srcNum,
  input  logic [PRIO_W-1:0]               srcPrio,
  output logic [NUM_SERVERS-1:0]          irq
);

  localparam int unsigned SRV_W = ADDR_W - PAGE_BITS;

  ctrlStrobeT       stb;
  logic [SRV_W-1:0] serverIdx;

  ipres_decode #(
    .NUM_SERVERS (NUM_SERVERS),
    .ADDR_W      (ADDR_W),
    .PAGE_BITS   (PAGE_BITS)
  ) u_decode (
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .reqAddr   (reqAddr),
    .reqSize   (reqSize),
    .stb       (stb),
    .serverIdx (serverIdx)
  );

  ipres_bank #(
    .NUM_SERVERS (NUM_SERVERS),
    .SRV_W       (SRV_W),
    .PRIO_W      (PRIO_W),
    .SRC_W       (SRC_W)
  ) u_bank (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .reqWrite  (reqWrite),
    .stb       (stb),
    .serverIdx (serverIdx),
    .wdata     (reqWdata),
    .srcValid  (srcValid),
    .srcServer (srcServer),
    .srcNum    (srcNum),
    .srcPrio   (srcPrio),
    .rspValid  (rspValid),
    .rspData   (rspData),
    .errPulse  (errPulse),
    .irq       (irq)
  );

endmodule

// File: rtl/ipres_chk.sv
module ipres_chk #(
  parameter int unsigned NUM_SERVERS = 4,
  parameter int unsigned ADDR_W      = 20,
  parameter int unsigned PAGE_BITS   = 12,
  parameter int unsigned DATA_W      = 32
) (
  input logic              clk,
  input logic              rstN,
  input logic              reqValid,
  input logic              reqWrite,
  input logic [ADDR_W-1:0] reqAddr,
  input logic [2:0]        reqSize,
  input logic              rspValid,
  input logic [DATA_W-1:0] rspData,
  input logic              errPulse
);

  localparam int unsigned SRV_W = ADDR_W - PAGE_BITS;
  localparam logic [SRV_W:0] SRV_LIMIT = (SRV_W+1)'(NUM_SERVERS);

  logic missingSrv;
  assign missingSrv = ({1'b0, reqAddr[ADDR_W-1:PAGE_BITS]} >= SRV_LIMIT);

  // R3
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rstN)
    reqValid |=> rspValid);

  // R3
  no_stray_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    !reqValid |=> !rspValid);

  // R3
  write_rsp_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqWrite) |=> (rspData == '0));

  // R12
  err_with_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    errPulse |-> rspValid);

  // R12
  bad_read_ones_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite) |=> (!errPulse || rspData == '1));

  // R2
  missing_server_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && missingSrv) |=> errPulse);

  // R5
  byte_read_narrow_chk: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && !reqWrite && reqSize == 3'd1) |=> (errPulse || rspData[DATA_W-1:8] == '0));

endmodule

bind ipres_mmio_top ipres_chk #(
  .NUM_SERVERS (NUM_SERVERS),
  .ADDR_W      (ADDR_W),
  .PAGE_BITS   (PAGE_BITS),
  .DATA_W      (PRIO_W + SRC_W)
) u_chk (
  .clk      (clk),
  .rstN     (rstN),
  .reqValid (reqValid),
  .reqWrite (reqWrite),
  .reqAddr  (reqAddr),
  .reqSize  (reqSize),
  .rspValid (rspValid),
  .rspData  (rspData),
  .errPulse (errPulse)
);

// File: tb/sim_ipres_mmio_top.sv
module sim_ipres_mmio_top;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        reqValid = 1'b0;
  logic        reqWrite = 1'b0;
  logic [19:0] reqAddr = '0;
  logic [2:0]  reqSize = 3'd4;
  logic [31:0] reqWdata = '0;
  logic        rspValid;
  logic [31:0] rspData;
  logic        errPulse;
  logic        srcValid = 1'b0;
  logic [7:0]  srcServer = '0;
  logic [23:0] srcNum = '0;
  logic [7:0]  srcPrio = '0;
  logic [3:0]  irq;

  int nChecks = 0;
  int nFails  = 0;

  always #4 clk = ~clk;

  ipres_mmio_top u0 (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqWrite(reqWrite),
    .reqAddr(reqAddr), .reqSize(reqSize), .reqWdata(reqWdata),
    .rspValid(rspValid), .rspData(rspData), .errPulse(errPulse),
    .srcValid(srcValid), .srcServer(srcServer), .srcNum(srcNum),
    .srcPrio(srcPrio), .irq(irq)
  );

  typedef struct packed {
    logic        wr;
    logic [2:0]  sz;
    logic [19:0] ad;
    logic [31:0] wd;
    logic [31:0] exp;
    logic        expErr;
    logic [3:0]  req;
  } vecT;

  localparam int NV = 35;
  localparam vecT VEC [NV] = '{
    '{1'b0, 3'd4, 20'h00000, 32'h0,        32'h00000000, 1'b0, 4'd4 },  // R4 reset poll
    '{1'b0, 3'd1, 20'h0000C, 32'h0,        32'h000000FF, 1'b0, 4'd9 },  // R9 reset value
    '{1'b1, 3'd1, 20'h00004, 32'h000000FF, 32'h0,        1'b0, 4'd7 },  // R7
    '{1'b0, 3'd1, 20'h00004, 32'h0,        32'h000000FF, 1'b0, 4'd5 },  // R5
    '{1'b0, 3'd1, 20'h00000, 32'h0,        32'h000000FF, 1'b0, 4'd5 },  // R5
    '{1'b1, 3'd1, 20'h0000C, 32'h00000040, 32'h0,        1'b0, 4'd9 },  // R9
    '{1'b0, 3'd4, 20'h00000, 32'h0,        32'hFF000002, 1'b0, 4'd10},  // R10
    '{1'b0, 3'd4, 20'h00000, 32'h0,        32'hFF000002, 1'b0, 4'd4 },  // R4 no side effect
    '{1'b0, 3'd4, 20'h00004, 32'h0,        32'hFF000002, 1'b0, 4'd6 },  // R6 accept
    '{1'b0, 3'd4, 20'h00000, 32'h0,        32'h40000000, 1'b0, 4'd6 },  // R6
    '{1'b1, 3'd4, 20'h00004, 32'hFF000002, 32'h0,        1'b0, 4'd8 },  // R8 end of interrupt
    '{1'b0, 3'd4, 20'h00000, 32'h0,        32'hFF000002, 1'b0, 4'd8 },  // R8
    '{1'b1, 3'd1, 20'h0000C, 32'h000000FF, 32'h0,        1'b0, 4'd9 },  // R9
    '{1'b0, 3'd4, 20'h00000, 32'h0,        32'hFF000000, 1'b0, 4'd10},  // R10
    '{1'b1, 3'd4, 20'h01010, 32'hDEADBEEF, 32'h0,        1'b0, 4'd11},  // R11
    '{1'b1, 3'd4, 20'h01014, 32'h12345678, 32'h0,        1'b0, 4'd11},  // R11
    '{1'b1, 3'd4, 20'h01018, 32'hA5A5A5A5, 32'h0,        1'b0, 4'd11},  // R11
    '{1'b0, 3'd4, 20'h01010, 32'h0,        32'hDEADBEEF, 1'b0, 4'd11},  // R11
    '{1'b0, 3'd4, 20'h01014, 32'h0,        32'h12345678, 1'b0, 4'd11},  // R11
    '{1'b0, 3'd4, 20'h01018, 32'h0,        32'hA5A5A5A5, 1'b0, 4'd11},  // R11
    '{1'b0, 3'd4, 20'h00010, 32'h0,        32'h00000000, 1'b0, 4'd2 },  // R2 page separation
    '{1'b0, 3'd1, 20'h01010, 32'h0,        32'hFFFFFFFF, 1'b1, 4'd11},  // R11 byte on link
    '{1'b1, 3'd1, 20'h01010, 32'h00000077, 32'h0,        1'b1, 4'd12},  // R12
    '{1'b0, 3'd4, 20'h01010, 32'h0,        32'hDEADBEEF, 1'b0, 4'd12},  // R12 unchanged
    '{1'b0, 3'd4, 20'h04000, 32'h0,        32'hFFFFFFFF, 1'b1, 4'd2 },  // R2 missing server
    '{1'b1, 3'd4, 20'h05004, 32'h00000000, 32'h0,        1'b1, 4'd2 },  // R2
    '{1'b0, 3'd4, 20'h00008, 32'h0,        32'hFFFFFFFF, 1'b1, 4'd12},  // R12 unknown offset
    '{1'b0, 3'd2, 20'h00000, 32'h0,        32'hFFFFFFFF, 1'b1, 4'd12},  // R12 size 2
    '{1'b0, 3'd1, 20'h00001, 32'h0,        32'hFFFFFFFF, 1'b1, 4'd5 },  // R5 not byte 0
    '{1'b0, 3'd3, 20'h00004, 32'h0,        32'hFFFFFFFF, 1'b1, 4'd12},  // R12 size 3
    '{1'b1, 3'd4, 20'h00000, 32'h12345678, 32'h0,        1'b1, 4'd12},  // R12 write to poll
    '{1'b1, 3'd4, 20'h0000C, 32'h00000011, 32'h0,        1'b1, 4'd9 },  // R9 word rejected
    '{1'b0, 3'd1, 20'h0000C, 32'h0,        32'h000000FF, 1'b0, 4'd9 },  // R9 unchanged
    '{1'b0, 3'd4, 20'h03000, 32'h0,        32'h00000000, 1'b0, 4'd1 },  // R1 untouched unit
    '{1'b0, 3'd4, 20'hFF000, 32'h0,        32'hFFFFFFFF, 1'b1, 4'd2 }   // R2 top server
  };

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFails++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic access(input logic wr, input logic [2:0] sz, input logic [19:0] ad,
                        input logic [31:0] wd, output logic [31:0] rd,
                        output logic er, output logic vl);
    @(negedge clk);
    reqValid = 1'b1; reqWrite = wr; reqSize = sz; reqAddr = ad; reqWdata = wd;
    @(posedge clk);
    #2;
    vl = rspValid; rd = rspData; er = errPulse;
    @(negedge clk);
    reqValid = 1'b0;
  endtask

  task automatic deliver(input logic [7:0] srv, input logic [23:0] num, input logic [7:0] pr);
    @(negedge clk);
    srcValid = 1'b1; srcServer = srv; srcNum = num; srcPrio = pr;
    @(negedge clk);
    srcValid = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nFails++;
    $display("FAIL watchdog expired");
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

  initial begin
    logic [31:0] rd;
    logic er, vl;

    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    // R1 reset state of outputs
    check("R1 rspValid", {31'b0, rspValid}, 32'h0);
    check("R1 errPulse", {31'b0, errPulse}, 32'h0);
    check("R1 irq", {28'b0, irq}, 32'h0);

    for (int k = 0; k < NV; k++) begin
      access(VEC[k].wr, VEC[k].sz, VEC[k].ad, VEC[k].wd, rd, er, vl);
      check($sformatf("R%0d vec%0d data", VEC[k].req, k), rd, VEC[k].exp);
      check($sformatf("R%0d vec%0d err", VEC[k].req, k), {31'b0, er}, {31'b0, VEC[k].expErr});
      check($sformatf("R3 vec%0d valid", k), {31'b0, vl}, 32'h1);
    end

    // R3 no response in the idle cycle after a request
    @(posedge clk); #2;
    check("R3 idle rspValid", {31'b0, rspValid}, 32'h0);

    // R14 / R13 on server 2 (current priority 0 masks everything)
    deliver(8'd2, 24'h000123, 8'h10);
    check("R13 masked irq", {31'b0, irq[2]}, 32'h0);
    access(1'b0, 3'd4, 20'h02000, 32'h0, rd, er, vl);
    check("R13 masked poll", rd, 32'h00000000);
    access(1'b1, 3'd1, 20'h02004, 32'h00000020, rd, er, vl);
    check("R13 irq raised", {31'b0, irq[2]}, 32'h1);
    access(1'b0, 3'd4, 20'h02000, 32'h0, rd, er, vl);
    check("R14 first delivery", rd, 32'h20000123);
    deliver(8'd2, 24'h000456, 8'h18);
    access(1'b0, 3'd4, 20'h02000, 32'h0, rd, er, vl);
    check("R14 weaker dropped", rd, 32'h20000123);
    deliver(8'd2, 24'h000789, 8'h08);
    access(1'b0, 3'd4, 20'h02000, 32'h0, rd, er, vl);
    check("R14 stronger replaces", rd, 32'h20000789);
    deliver(8'd7, 24'h000999, 8'h01);
    check("R14 missing server", {28'b0, irq}, 32'h4);
    access(1'b0, 3'd4, 20'h02004, 32'h0, rd, er, vl);
    check("R6 accept external", rd, 32'h20000789);
    check("R13 irq after accept", {31'b0, irq[2]}, 32'h0);
    access(1'b0, 3'd4, 20'h02000, 32'h0, rd, er, vl);
    check("R6 source cleared", rd, 32'h08000000);
    access(1'b0, 3'd4, 20'h02004, 32'h0, rd, er, vl);
    check("R6 empty accept", rd, 32'h08000000);
    access(1'b0, 3'd4, 20'h02000, 32'h0, rd, er, vl);
    check("R6 empty accept no change", rd, 32'h08000000);
    access(1'b1, 3'd4, 20'h02004, 32'h20000000, rd, er, vl);
    access(1'b0, 3'd1, 20'h02004, 32'h0, rd, er, vl);
    check("R8 priority restored", rd, 32'h00000020);

    // R10 request against external on server 3
    access(1'b1, 3'd1, 20'h03004, 32'h000000FF, rd, er, vl);
    deliver(8'd3, 24'h000055, 8'h30);
    access(1'b1, 3'd1, 20'h0300C, 32'h00000030, rd, er, vl);
    access(1'b0, 3'd4, 20'h03000, 32'h0, rd, er, vl);
    check("R10 tie goes external", rd, 32'hFF000055);
    access(1'b1, 3'd1, 20'h0300C, 32'h0000002F, rd, er, vl);
    access(1'b0, 3'd4, 20'h03000, 32'h0, rd, er, vl);
    check("R10 request preempts", rd, 32'hFF000002);
    access(1'b0, 3'd4, 20'h03004, 32'h0, rd, er, vl);
    check("R10 accept request", rd, 32'hFF000002);
    access(1'b0, 3'd4, 20'h03000, 32'h0, rd, er, vl);
    check("R10 external now masked", rd, 32'h2F000000);
    check("R13 irq low when masked", {31'b0, irq[3]}, 32'h0);

    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", nChecks, nFails);
    $finish;
  end

endmodule